// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of device interfaces and a processor core. Each device holds its request line high for as long as it wants service. The block never latches a request: it looks at the lines only when the core signals the end of an instruction. At that point it finds the most urgent request. It takes that request only if the request is strictly more urgent than the processor's current priority level. Lower numbers mean more urgent, so a level of zero shuts every source out.

When a request is taken, the block does four things. It raises an interrupt-valid flag and presents the source's index as a vector for the service-routine table. It records the program counter of the interrupted instruction. It raises the processor level to the level of the taken source. It pushes the previous level and the captured PC onto a small context stack, so interrupts can nest. A return strobe pops that stack, which restores both the level and the saved PC.

The control path has two states. ST_WAIT is the state where requests are sampled. In ST_WAIT, the transition "take" goes to ST_OFFER when an eligible request is present at an instruction boundary. ST_OFFER holds the offer steady. In ST_OFFER, the transition "acknowledge" returns to ST_WAIT.

Top module: `ivc_ctrl`

## Requirements
- R1: After reset, int_valid is 0, cur_level is 15 (all ones), int_vector and saved_pc are 0, every source priority is 15, and the context stack is empty, so a return strobe leaves cur_level at 15.
- R2: Requests are evaluated only on a clock edge where insn_end is 1 in ST_WAIT. With insn_end at 0, no request raises int_valid.
- R3: A request is taken only if its source priority is numerically strictly less than cur_level. A source whose priority equals cur_level is not taken.
- R4: Among the pending requests, the one with the numerically smallest priority wins. Equal priorities resolve to the lowest line number, which appears on int_vector.
- R5: While cur_level is 0, no request is taken.
- R6: Once int_valid rises, it stays 1 until a clock edge with ack at 1. The next cycle it is 0. int_vector, saved_pc and cur_level do not change while int_valid is 1.
- R7: On the edge that takes a request, saved_pc receives pc_in, cur_level receives the winner's priority, and int_valid is 1 from the next cycle.
- R8: A ret pulse in ST_WAIT with a non-empty stack pops the latest entry and loads its level into cur_level and its PC into saved_pc. A ret pulse with an empty stack changes nothing. A ret pulse also blocks acceptance and level writes in that cycle.
- R9: With four nested interrupts on the stack (default depth), no further request is taken and cur_level is unchanged.
- R10: Requests are level-sensitive and are not latched. A request that drops before the sampling edge is not taken.
- R11: A level write (lvl_wr_en) loads lvl_wr_val into cur_level on an ST_WAIT edge where neither ret nor an acceptance occurs. In ST_OFFER it is ignored.
- R12: A source-priority write (prio_wr_en) updates the priority of line prio_wr_idx in any state. It takes effect from the next edge's arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Level-held device requests |
| insn_end | input | 1 | Instruction boundary strobe |
| ack | input | 1 | Processor acknowledge of the offered interrupt |
| ret | input | 1 | Return-from-interrupt strobe |
| prio_wr_en | input | 1 | Source priority write enable |
| prio_wr_idx | input | SRC_W | Line whose priority is written |
| prio_wr_val | input | PRIO_W | New source priority |
| lvl_wr_en | input | 1 | Processor level write enable |
| lvl_wr_val | input | PRIO_W | New processor level |
| pc_in | input | PC_W | PC of the current instruction |
| int_valid | output | 1 | Interrupt offered to the processor |
| int_vector | output | SRC_W | Index of the offered source |
| saved_pc | output | PC_W | Captured or restored PC |
| cur_level | output | PRIO_W | Current processor priority level |

## Verification
The bench builds the block with its defaults: eight lines, 4-bit priorities, a 32-bit PC and a four-entry stack. With these values, a nesting chain of four interrupts fills the stack and reaches the full-stack refusal in a few cycles. The full priority range fits in a handful of writes, from the masking level 0 to the reset level 15. Directed cases cover the tie on equal priorities, the equal-priority refusal, pops from an empty stack and level writes during an offer. A long seeded random run then mixes nesting, returns and priority rewrites against a reference model.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_OFFER = 1'b1
    } ivc_state_e;
endpackage

// File: rtl/ivc_prio_table.sv
module ivc_prio_table #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SRC_W-1:0]          wr_idx,
    input  logic [PRIO_W-1:0]         wr_val,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
    // One priority register per source line; all start at the least urgent value.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [PRIO_W-1:0] prio_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '1;
            end else if (wr_en && (wr_idx == SRC_W'(g))) begin
                prio_q <= wr_val;
            end
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
    end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      any,
    output logic [SRC_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    // Linear scan: a later line replaces the winner only when strictly more
    // urgent, so equal priorities stay with the lowest line number.
    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                if (!any || (prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
                    any      = 1'b1;
                    win_idx  = SRC_W'(i);
                    win_prio = prio_flat[i*PRIO_W +: PRIO_W];
                end
            end
        end
    end
endmodule

// File: rtl/ivc_ctx_stack.sv
module ivc_ctx_stack #(
    parameter int PRIO_W = 4,
    parameter int PC_W   = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_lvl,
    input  logic [PC_W-1:0]   push_pc,
    output logic [PRIO_W-1:0] top_lvl,
    output logic [PC_W-1:0]   top_pc,
    output logic              full,
    output logic              empty
);
    logic [CNT_W-1:0]  cnt_q;
    logic [PRIO_W-1:0] lvl_mem [DEPTH];
    logic [PC_W-1:0]   pc_mem  [DEPTH];
    logic [IDX_W-1:0]  wr_ptr;
    logic [IDX_W-1:0]  rd_ptr;

    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign empty  = (cnt_q == '0);
    assign wr_ptr = IDX_W'(cnt_q);
    assign rd_ptr = IDX_W'(cnt_q - CNT_W'(1));

    assign top_lvl = lvl_mem[rd_ptr];
    assign top_pc  = pc_mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            lvl_mem[wr_ptr] <= push_lvl;
            pc_mem[wr_ptr]  <= push_pc;
        end
    end
endmodule

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
    import ivc_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int PRIO_W      = 4,
    parameter int PC_W        = 32,
    parameter int STACK_DEPTH = 4,
    localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               insn_end,
    input  logic               ack,
    input  logic               ret,
    input  logic               prio_wr_en,
    input  logic [SRC_W-1:0]   prio_wr_idx,
    input  logic [PRIO_W-1:0]  prio_wr_val,
    input  logic               lvl_wr_en,
    input  logic [PRIO_W-1:0]  lvl_wr_val,
    input  logic [PC_W-1:0]    pc_in,
    output logic               int_valid,
    output logic [SRC_W-1:0]   int_vector,
    output logic [PC_W-1:0]    saved_pc,
    output logic [PRIO_W-1:0]  cur_level
);
    ivc_state_e state_q, state_d;

    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      arb_any;
    logic [SRC_W-1:0]          arb_idx;
    logic [PRIO_W-1:0]         arb_prio;
    logic [PRIO_W-1:0]         stk_lvl;
    logic [PC_W-1:0]           stk_pc;
    logic                      stk_full, stk_empty;
    logic                      take, do_pop, do_lw;
    logic [PRIO_W-1:0]         level_q;
    logic [SRC_W-1:0]          vec_q;
    logic [PC_W-1:0]           spc_q;

    ivc_prio_table #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prio_wr_en),
        .wr_idx    (prio_wr_idx),
        .wr_val    (prio_wr_val),
        .prio_flat (prio_flat)
    );

    ivc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .req       (irq_req),
        .prio_flat (prio_flat),
        .any       (arb_any),
        .win_idx   (arb_idx),
        .win_prio  (arb_prio)
    );

    ivc_ctx_stack #(.PRIO_W(PRIO_W), .PC_W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .pop      (do_pop),
        .push_lvl (level_q),
        .push_pc  (pc_in),
        .top_lvl  (stk_lvl),
        .top_pc   (stk_pc),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    // Event decode, ordered: return, then acceptance, then level write.
    always_comb begin
        take   = 1'b0;
        do_pop = 1'b0;
        do_lw  = 1'b0;
        if (state_q == ST_WAIT) begin
            if (ret) begin
                do_pop = !stk_empty;
            end else if (insn_end && arb_any && (arb_prio < level_q) && !stk_full) begin
                take = 1'b1;
            end else begin
                do_lw = lvl_wr_en;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (take) state_d = ST_OFFER;
            ST_OFFER: if (ack)  state_d = ST_WAIT;
            default:            state_d = ST_WAIT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '1;
            vec_q   <= '0;
            spc_q   <= '0;
        end else if (take) begin
            level_q <= arb_prio;
            vec_q   <= arb_idx;
            spc_q   <= pc_in;
        end else if (do_pop) begin
            level_q <= stk_lvl;
            spc_q   <= stk_pc;
        end else if (do_lw) begin
            level_q <= lvl_wr_val;
        end
    end

    assign int_valid  = (state_q == ST_OFFER);
    assign int_vector = vec_q;
    assign saved_pc   = spc_q;
    assign cur_level  = level_q;
endmodule

// File: rtl/ivc_ctrl_chk.sv
module ivc_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    parameter int PC_W    = 32,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               insn_end,
    input logic               ack,
    input logic               int_valid,
    input logic [SRC_W-1:0]   int_vector,
    input logic [PC_W-1:0]    saved_pc,
    input logic [PRIO_W-1:0]  cur_level
);
    a_r2_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_valid) |-> $past(insn_end));

    a_r3_strictly_more_urgent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_valid) |-> (cur_level < $past(cur_level)));

    a_r4_vector_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_valid) |-> (($past(irq_req) & (NUM_SRC'(1) << int_vector)) != '0));

    a_r5_level_zero_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level == '0 && !int_valid) |=> !int_valid);

    a_r6_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (int_valid && !ack) |=> int_valid);

    a_r6_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |=> ($stable(int_vector) && $stable(saved_pc)));

    a_r11_level_frozen_in_offer: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |=> $stable(cur_level));
endmodule

bind ivc_ctrl ivc_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .PC_W    (PC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .insn_end   (insn_end),
    .ack        (ack),
    .int_valid  (int_valid),
    .int_vector (int_vector),
    .saved_pc   (saved_pc),
    .cur_level  (cur_level)
);

// File: tb/ivc_ctrl_bench.sv
module ivc_ctrl_bench;
    localparam int NS  = 8;
    localparam int PW  = 4;
    localparam int PCW = 32;
    localparam int SD  = 4;
    localparam int SW  = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n = 1'b0;
    logic [NS-1:0]  irq_req = '0;
    logic           insn_end = 1'b0, ack = 1'b0, ret = 1'b0;
    logic           prio_wr_en = 1'b0, lvl_wr_en = 1'b0;
    logic [SW-1:0]  prio_wr_idx = '0;
    logic [PW-1:0]  prio_wr_val = '0, lvl_wr_val = '0;
    logic [PCW-1:0] pc_in = '0;
    logic           int_valid;
    logic [SW-1:0]  int_vector;
    logic [PCW-1:0] saved_pc;
    logic [PW-1:0]  cur_level;

    ivc_ctrl #(.NUM_SRC(NS), .PRIO_W(PW), .PC_W(PCW), .STACK_DEPTH(SD)) u_ivc_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_end(insn_end), .ack(ack),
        .ret(ret), .prio_wr_en(prio_wr_en), .prio_wr_idx(prio_wr_idx),
        .prio_wr_val(prio_wr_val), .lvl_wr_en(lvl_wr_en), .lvl_wr_val(lvl_wr_val),
        .pc_in(pc_in), .int_valid(int_valid), .int_vector(int_vector),
        .saved_pc(saved_pc), .cur_level(cur_level)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic [PW-1:0]  m_sprio [NS];
    logic [PW-1:0]  m_slvl  [SD];
    logic [PCW-1:0] m_spcs  [SD];
    logic [PW-1:0]  m_level;
    logic [SW-1:0]  m_vec;
    logic [PCW-1:0] m_spc;
    bit             m_offer;
    int             m_cnt;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NS; i++) m_sprio[i] = '1;
        m_level = '1; m_vec = '0; m_spc = '0; m_offer = 0; m_cnt = 0;
    endtask

    function automatic int best_prio(output int idx);
        int b = 16;
        idx = 0;
        for (int i = 0; i < NS; i++)
            if (irq_req[i] && int'(m_sprio[i]) < b) begin b = int'(m_sprio[i]); idx = i; end
        return b;
    endfunction

    task automatic model_step();
        int bi;
        int b = best_prio(bi);
        if (m_offer) begin
            if (ack) m_offer = 0;
        end else if (ret) begin
            if (m_cnt > 0) begin
                m_cnt--; m_level = m_slvl[m_cnt]; m_spc = m_spcs[m_cnt];
            end
        end else if (insn_end && b < int'(m_level) && m_cnt < SD) begin
            m_slvl[m_cnt] = m_level; m_spcs[m_cnt] = pc_in; m_cnt++;
            m_level = PW'(b); m_vec = SW'(bi); m_spc = pc_in; m_offer = 1;
        end else if (lvl_wr_en) begin
            m_level = lvl_wr_val;
        end
        if (prio_wr_en) m_sprio[prio_wr_idx] = prio_wr_val;
    endtask

    // Apply current inputs for one edge, then compare at the next falling edge.
    task automatic step();
        model_step();
        @(negedge clk);
        chk("R2 int_valid", 64'(int_valid), 64'(m_offer));
        chk("R4 int_vector", 64'(int_vector), 64'(m_vec));
        chk("R7 saved_pc", 64'(saved_pc), 64'(m_spc));
        chk("R8 cur_level", 64'(cur_level), 64'(m_level));
        insn_end = 0; ack = 0; ret = 0; prio_wr_en = 0; lvl_wr_en = 0;
    endtask

    task automatic set_prio(input int idx, input int val);
        prio_wr_en = 1; prio_wr_idx = SW'(idx); prio_wr_val = PW'(val);
        step();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 valid", 64'(int_valid), 0);
        chk("R1 level", 64'(cur_level), 15);
        chk("R1 vector", 64'(int_vector), 0);
        chk("R1 saved_pc", 64'(saved_pc), 0);
        ret = 1; step();
        chk("R1 empty stack ret", 64'(cur_level), 15);
        irq_req = 8'hFF; insn_end = 1; step();
        chk("R1 reset priorities", 64'(int_valid), 0);
        irq_req = '0;

        set_prio(3, 5); set_prio(5, 2); set_prio(6, 2);
        irq_req = 8'h68; step();
        chk("R2 no boundary", 64'(int_valid), 0);
        insn_end = 1; pc_in = 32'h1000; step();
        chk("R2 taken", 64'(int_valid), 1);
        chk("R4 tie lowest line", 64'(int_vector), 5);
        chk("R7 pc captured", 64'(saved_pc), 32'h1000);
        chk("R7 level raised", 64'(cur_level), 2);
        pc_in = 32'h2222; irq_req = 8'hFF;
        for (int k = 0; k < 3; k++) begin
            insn_end = 1; step();
            chk("R6 held", 64'(int_valid), 1);
            chk("R6 vector stable", 64'(int_vector), 5);
            chk("R6 pc stable", 64'(saved_pc), 32'h1000);
        end
        lvl_wr_en = 1; lvl_wr_val = 9; step();
        chk("R11 ignored in offer", 64'(cur_level), 2);
        ack = 1; step();
        chk("R6 dropped after ack", 64'(int_valid), 0);

        irq_req = 8'h40; insn_end = 1; step();
        chk("R3 equal not taken", 64'(int_valid), 0);
        set_prio(3, 1);
        irq_req = 8'h48; insn_end = 1; pc_in = 32'h3000; step();
        chk("R3 more urgent taken", 64'(int_vector), 3);
        chk("R7 nested level", 64'(cur_level), 1);
        ack = 1; step();
        ret = 1; step();
        chk("R8 pop level", 64'(cur_level), 2);
        chk("R8 pop pc", 64'(saved_pc), 32'h3000);
        ret = 1; step();
        chk("R8 pop level 2", 64'(cur_level), 15);
        chk("R8 pop pc 2", 64'(saved_pc), 32'h1000);
        ret = 1; step();
        chk("R8 empty pop ignored", 64'(cur_level), 15);

        irq_req = '0; lvl_wr_en = 1; lvl_wr_val = 0; step();
        chk("R11 level write", 64'(cur_level), 0);
        irq_req = 8'hFF; insn_end = 1; step();
        chk("R5 level zero masks", 64'(int_valid), 0);
        irq_req = '0; lvl_wr_en = 1; lvl_wr_val = 15; step();

        set_prio(0, 10); set_prio(1, 8); set_prio(2, 6); set_prio(3, 4); set_prio(4, 2);
        for (int k = 0; k < 4; k++) begin
            irq_req = NS'((1 << (k + 1)) - 1); insn_end = 1; pc_in = 32'h4000 + k; step();
            chk("R9 nest vector", 64'(int_vector), 64'(k));
            ack = 1; step();
        end
        irq_req = 8'h1F; insn_end = 1; step();
        chk("R9 full stack refuses", 64'(int_valid), 0);
        chk("R9 level kept", 64'(cur_level), 4);
        irq_req = '0;
        for (int k = 0; k < 4; k++) begin ret = 1; step(); end
        chk("R8 unwound", 64'(cur_level), 15);

        irq_req = 8'h10; step();
        irq_req = '0; insn_end = 1; step();
        chk("R10 withdrawn not taken", 64'(int_valid), 0);
        irq_req = 8'h10; insn_end = 1; step();
        chk("R10 held taken", 64'(int_vector), 4);
        ack = 1; step(); ret = 1; step();

        irq_req = 8'h11; set_prio(4, 12);
        insn_end = 1; step();
        chk("R12 new priority used", 64'(int_vector), 0);
        ack = 1; step(); ret = 1; step();

        // Seeded random phase against the reference model
        void'($urandom(32'h5EED));
        for (int c = 0; c < 4000; c++) begin
            irq_req  = NS'($urandom) & NS'($urandom);
            insn_end = ($urandom % 2) == 0;
            ack      = int_valid && (($urandom % 3) == 0);
            ret      = ($urandom % 7) == 0;
            pc_in    = $urandom;
            prio_wr_en  = ($urandom % 8) == 0;
            prio_wr_idx = SW'($urandom);
            prio_wr_val = PW'($urandom);
            lvl_wr_en   = ($urandom % 20) == 0;
            lvl_wr_val  = PW'($urandom);
            step();
        end
        finish_run();
    end
endmodule